// File: doc/BRIEF.md
# YCbCr-to-RGB Pixel Feed with Paired DMA Fetch

This block sits between a frame-store DMA engine and a display DAC. It asks for pixel data as packed 4:2:2 words on two DMA request/acknowledge channels. One channel carries a luma word that holds two neighbouring pixels. The other carries the chroma word that those two pixels share. Complete pairs are parked in two pair slots that work as a ping-pong. One slot is refilled from DMA while the other is read out pixel by pixel.

Each time the display timing raises its pixel-valid strobe, the next pixel is converted to RGB. The conversion uses fixed-point coefficients scaled by 64 and signed radix-4 Booth multipliers. Each result is clamped to the 8-bit unsigned range. On lines flagged by the line-parity input the output is bit-inverted, which suits panels whose common electrode alternates polarity line by line. If no pair is ready when a pixel is wanted, the previous colour is held and an underflow pulse is raised.

Top module: `ycc_rgb_pipe`

## Requirements
- R1: While `rst_n` is low, `red`, `green` and `blue` are 0, `out_valid` and `underflow` are 0, and both bits of `dma_req` are 0.
- R2: Bit 0 of `dma_req` (luma channel) is high while the slot being filled lacks its luma word. Bit 1 (chroma channel) is high while that slot lacks its chroma word. Both bits are low whenever two complete pairs are held.
- R3: A word on `dma_data` is taken in a cycle where an acknowledge bit and its request bit are both high. At most one acknowledge bit is high per cycle. In the luma word, bits [7:0] are the first pixel and bits [15:8] the second. In the chroma word, bits [7:0] are Cb and bits [15:8] are Cr. All three are two's complement, and the luma has been offset by −128.
- R4: When `pix_valid` is high and a pair is held, one pixel appears on the colour outputs in the next cycle with `out_valid` high. Pixels come first then second within a pair, and pairs in fetch order. A slot is freed after its second pixel.
- R5: With Y' = Y + 128, the outputs are R = Y' + ((90·Cr + 32) >>> 6), G = Y' − ((22·Cb + 46·Cr + 32) >>> 6) and B = Y' + ((113·Cb + 32) >>> 6), where >>> is an arithmetic shift.
- R6: Each channel result below 0 gives 0, and each above 255 gives 255.
- R7: When `line_odd` is high in the consuming cycle, each output byte is the bitwise inverse of the clamped value.
- R8: When `pix_valid` is high and no pair is held, `underflow` is high in the next cycle with `out_valid` low. The colour outputs are unchanged and no data is consumed.
- R9: When `pix_valid` is low, `out_valid` and `underflow` are low in the next cycle and the colour outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_req | output | 2 | DMA requests: bit 0 luma word, bit 1 chroma word |
| dma_ack | input | 2 | DMA acknowledges, same bit order; data valid on `dma_data` |
| dma_data | input | 16 | DMA read data |
| pix_valid | input | 1 | Display timing wants one pixel this cycle |
| line_odd | input | 1 | Current line is driven inverted |
| red | output | 8 | Red to DAC |
| green | output | 8 | Green to DAC |
| blue | output | 8 | Blue to DAC |
| out_valid | output | 1 | A new pixel was placed on the colour outputs |
| underflow | output | 1 | A pixel was wanted but no pair was ready |

## Verification
The hardest situation to reach from the ports is the cycle where a slot's second pixel is read out while the other slot's last word arrives from DMA. The freed slot must then start requesting again at once, with no gap and no double booking. The stimulus reaches this by streaming pixels back to back while the DMA acknowledge is stalled at random. This makes the fetch rate drift above and below the pixel rate, so full-to-empty turnovers, same-cycle fill and release, and underflows all occur many times. A behavioural reference holds the delivered pairs in a queue and predicts requests, colours, underflow and valid on every cycle.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
   localparam int unsigned SAMPLE_W = 8;
   localparam int unsigned FRAC_W   = 6;
   localparam int unsigned WIDE_W   = 12;
   localparam int          K_R_CR   = 90;
   localparam int          K_G_CB   = 22;
   localparam int          K_G_CR   = 46;
   localparam int          K_B_CB   = 113;

   typedef enum int {
      CH_LUMA   = 0,
      CH_CHROMA = 1
   } dma_ch_e;
endpackage

// File: rtl/ycc_booth_mul.sv
module ycc_booth_mul #(
   parameter int unsigned AW = 9,
   parameter int unsigned BW = 8
) (
   input  logic signed [AW-1:0]    a,
   input  logic signed [BW-1:0]    b,
   output logic signed [AW+BW-1:0] p
);
   localparam int unsigned PW = AW + BW;
   localparam int unsigned ND = BW / 2;

   initial begin
      assert (BW % 2 == 0) else $error("multiplier width must be even");
      assert (AW >= 2)     else $error("multiplicand too narrow");
   end

   logic        [BW:0]   bx;
   logic signed [PW-1:0] ax, ax2;
   logic signed [PW-1:0] pp [ND];

   assign bx  = {b, 1'b0};
   assign ax  = PW'(a);
   assign ax2 = ax <<< 1;

   for (genvar i = 0; i < ND; i++) begin : g_digit
      logic signed [PW-1:0] dig;
      always_comb begin
         unique case (bx[2*i+2 -: 3])
            3'b001, 3'b010: dig = ax;
            3'b011:         dig = ax2;
            3'b100:         dig = -ax2;
            3'b101, 3'b110: dig = -ax;
            default:        dig = '0;
         endcase
      end
      assign pp[i] = dig <<< (2*i);
   end

   always_comb begin
      p = '0;
      for (int i = 0; i < ND; i++) p = p + pp[i];
   end
endmodule

// File: rtl/ycc_matrix.sv
module ycc_matrix #(
   parameter int unsigned SW        = 8,
   parameter int unsigned IW        = 12,
   parameter int unsigned FRAC      = 6,
   parameter int          C_RV      = 90,
   parameter int          C_GU      = 22,
   parameter int          C_GV      = 46,
   parameter int          C_BU      = 113,
   parameter bit          USE_BOOTH = 1'b1
) (
   input  logic signed [SW-1:0] y,
   input  logic signed [SW-1:0] cb,
   input  logic signed [SW-1:0] cr,
   input  logic                 inv,
   output logic        [SW-1:0] r,
   output logic        [SW-1:0] g,
   output logic        [SW-1:0] b
);
   localparam int unsigned AW   = SW + 1;
   localparam int unsigned CW   = SW;
   localparam int unsigned PW   = AW + CW;
   localparam int unsigned SUMW = PW + 1;
   localparam logic signed [SUMW-1:0] RND = SUMW'(2**(FRAC-1));
   localparam logic signed [IW-1:0]   TOP = IW'((1 << SW) - 1);

   initial begin
      assert (FRAC >= 1)   else $error("FRAC must be at least 1");
      assert (IW > SW + 1) else $error("intermediate width too small");
      assert (C_RV < 2**(CW-1) && C_GU < 2**(CW-1) && C_GV < 2**(CW-1) && C_BU < 2**(CW-1))
         else $error("coefficient does not fit signed width");
   end

   logic signed [AW-1:0] mc [4];
   logic signed [CW-1:0] mk [4];
   logic signed [PW-1:0] pr [4];

   assign mc[0] = AW'(cr);  assign mk[0] = CW'(C_RV);
   assign mc[1] = AW'(cb);  assign mk[1] = CW'(C_GU);
   assign mc[2] = AW'(cr);  assign mk[2] = CW'(C_GV);
   assign mc[3] = AW'(cb);  assign mk[3] = CW'(C_BU);

   for (genvar i = 0; i < 4; i++) begin : g_mul
      if (USE_BOOTH) begin : g_booth
         ycc_booth_mul #(.AW(AW), .BW(CW)) u_mul (.a(mc[i]), .b(mk[i]), .p(pr[i]));
      end else begin : g_plain
         assign pr[i] = mc[i] * mk[i];
      end
   end

   logic signed [IW-1:0]   yo;
   logic signed [SUMW-1:0] acc_r, acc_g, acc_b, sh_r, sh_g, sh_b;
   logic signed [IW-1:0]   wide [3];

   // offset-binary flip adds 128 to the signed luma
   assign yo = $signed(IW'({~y[SW-1], y[SW-2:0]}));

   always_comb begin
      acc_r   = SUMW'(pr[0]) + RND;
      acc_g   = SUMW'(pr[1]) + SUMW'(pr[2]) + RND;
      acc_b   = SUMW'(pr[3]) + RND;
      sh_r    = acc_r >>> FRAC;
      sh_g    = acc_g >>> FRAC;
      sh_b    = acc_b >>> FRAC;
      wide[0] = yo + IW'(sh_r);
      wide[1] = yo - IW'(sh_g);
      wide[2] = yo + IW'(sh_b);
   end

   logic [SW-1:0] outv [3];

   for (genvar c = 0; c < 3; c++) begin : g_chan
      logic [SW-1:0] sat;
      always_comb begin
         if (wide[c] < 0)        sat = '0;
         else if (wide[c] > TOP) sat = '1;
         else                    sat = wide[c][SW-1:0];
      end
      assign outv[c] = inv ? ~sat : sat;
   end

   assign r = outv[0];
   assign g = outv[1];
   assign b = outv[2];
endmodule

// File: rtl/ycc_pair_buf.sv
module ycc_pair_buf
   import ycc_pkg::*;
#(
   parameter int unsigned SW = SAMPLE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic [1:0]           dma_req,
   input  logic [1:0]           dma_ack,
   input  logic [2*SW-1:0]      dma_data,
   input  logic                 pull,
   output logic                 avail,
   output logic signed [SW-1:0] y,
   output logic signed [SW-1:0] cb,
   output logic signed [SW-1:0] cr
);
   localparam int unsigned WW = 2 * SW;

   typedef struct packed {
      logic [WW-1:0] luma;
      logic [WW-1:0] chroma;
   } slot_t;

   slot_t      slot [2];
   slot_t      cur;
   logic [1:0] full;
   logic       wr_sel, rd_sel, phase, got_l, got_c;
   logic       fill_free, take_l, take_c, done, pop;

   assign fill_free          = ~full[wr_sel];
   assign dma_req[CH_LUMA]   = rst_n & fill_free & ~got_l;
   assign dma_req[CH_CHROMA] = rst_n & fill_free & ~got_c;
   assign take_l             = dma_ack[CH_LUMA] & dma_req[CH_LUMA];
   assign take_c             = dma_ack[CH_CHROMA] & dma_req[CH_CHROMA];
   assign done               = fill_free & (got_l | take_l) & (got_c | take_c);
   assign avail              = full[rd_sel];
   assign pop                = pull & avail & phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot[0] <= '0;
         slot[1] <= '0;
         full    <= '0;
         wr_sel  <= 1'b0;
         rd_sel  <= 1'b0;
         phase   <= 1'b0;
         got_l   <= 1'b0;
         got_c   <= 1'b0;
      end else begin
         if (take_l) slot[wr_sel].luma   <= dma_data;
         if (take_c) slot[wr_sel].chroma <= dma_data;
         got_l <= done ? 1'b0 : (got_l | take_l);
         got_c <= done ? 1'b0 : (got_c | take_c);
         if (done) wr_sel <= ~wr_sel;
         for (int k = 0; k < 2; k++) begin
            if (done && wr_sel == 1'(k))     full[k] <= 1'b1;
            else if (pop && rd_sel == 1'(k)) full[k] <= 1'b0;
         end
         if (pull && avail) phase <= ~phase;
         if (pop) rd_sel <= ~rd_sel;
      end
   end

   assign cur = slot[rd_sel];
   assign y   = $signed(phase ? cur.luma[WW-1:SW] : cur.luma[SW-1:0]);
   assign cb  = $signed(cur.chroma[SW-1:0]);
   assign cr  = $signed(cur.chroma[WW-1:SW]);

   assert_req_idle_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (&full) |-> (dma_req == 2'b00));

   assert_single_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dma_ack));

   assert_pair_kept_after_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pull && avail && !phase) |=> avail);
endmodule

// File: rtl/ycc_rgb_pipe.sv
module ycc_rgb_pipe
   import ycc_pkg::*;
#(
   parameter int unsigned SW        = SAMPLE_W,
   parameter int unsigned IW        = WIDE_W,
   parameter int unsigned FRAC      = FRAC_W,
   parameter int          C_RV      = K_R_CR,
   parameter int          C_GU      = K_G_CB,
   parameter int          C_GV      = K_G_CR,
   parameter int          C_BU      = K_B_CB,
   parameter bit          USE_BOOTH = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [1:0]      dma_req,
   input  logic [1:0]      dma_ack,
   input  logic [2*SW-1:0] dma_data,
   input  logic            pix_valid,
   input  logic            line_odd,
   output logic [SW-1:0]   red,
   output logic [SW-1:0]   green,
   output logic [SW-1:0]   blue,
   output logic            out_valid,
   output logic            underflow
);
   logic                 avail;
   logic signed [SW-1:0] y, cb, cr;
   logic        [SW-1:0] cv_r, cv_g, cv_b;

   ycc_pair_buf #(.SW(SW)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .dma_req  (dma_req),
      .dma_ack  (dma_ack),
      .dma_data (dma_data),
      .pull     (pix_valid),
      .avail    (avail),
      .y        (y),
      .cb       (cb),
      .cr       (cr)
   );

   ycc_matrix #(
      .SW(SW), .IW(IW), .FRAC(FRAC),
      .C_RV(C_RV), .C_GU(C_GU), .C_GV(C_GV), .C_BU(C_BU),
      .USE_BOOTH(USE_BOOTH)
   ) u_mat (
      .y   (y),
      .cb  (cb),
      .cr  (cr),
      .inv (line_odd),
      .r   (cv_r),
      .g   (cv_g),
      .b   (cv_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         red       <= '0;
         green     <= '0;
         blue      <= '0;
         out_valid <= 1'b0;
         underflow <= 1'b0;
      end else begin
         out_valid <= pix_valid & avail;
         underflow <= pix_valid & ~avail;
         if (pix_valid && avail) begin
            red   <= cv_r;
            green <= cv_g;
            blue  <= cv_b;
         end
      end
   end

   assert_hold_on_starve_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !avail) |=> (underflow && !out_valid &&
                                 $stable(red) && $stable(green) && $stable(blue)));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> (!out_valid && !underflow &&
                      $stable(red) && $stable(green) && $stable(blue)));

   assert_valid_follows_demand_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(pix_valid));
endmodule

// File: tb/sim_ycc_rgb_pipe.sv
`timescale 1ns/1ps
module sim_ycc_rgb_pipe;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  req;
   logic [1:0]  ack = 2'b00;
   logic [15:0] data = 16'h0000;
   logic        pv = 1'b0;
   logic        lodd = 1'b0;
   logic [7:0]  r, g, b;
   logic        ov, und;

   always #2.5 clk = ~clk;

   ycc_rgb_pipe u0 (
      .clk(clk), .rst_n(rst_n), .dma_req(req), .dma_ack(ack), .dma_data(data),
      .pix_valid(pv), .line_odd(lodd), .red(r), .green(g), .blue(b),
      .out_valid(ov), .underflow(und)
   );

   int total = 0;
   int bad = 0;
   bit ack_en = 1'b0;
   int stall = 0;
   int nl = 0, nc = 0;

   logic [15:0] dir_l [3] = '{16'h7F80, 16'h0000, 16'h10F0};
   logic [15:0] dir_c [3] = '{16'h7F80, 16'h807F, 16'h0000};

   // reference model state
   logic [31:0] q [$];
   int          ph = 0;
   logic [15:0] pl = 0, pc = 0;
   bit          gl = 0, gc = 0;
   int          er = 0, eg = 0, eb = 0;
   bit          ev = 0, eu = 0;
   string       etag = "R1";
   string       vtag = "R1";

   task automatic chk(string tag, int act, int exp, string nm);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
      end
   endtask

   function automatic int sat8(int v, ref bit hit);
      if (v < 0)   begin hit = 1; return 0;   end
      if (v > 255) begin hit = 1; return 255; end
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); ph = 0; gl = 0; gc = 0;
         er = 0; eg = 0; eb = 0; ev = 0; eu = 0;
         etag = "R1"; vtag = "R1";
      end else begin
         ev = 0; eu = 0;
         vtag = pv ? "R4 R8" : "R9";
         if (pv) begin
            if (q.size() > 0) begin
               logic [31:0] w;
               int yy, cbv, crv, yp, rr, gg, bbv, mask;
               bit hit;
               w    = q[0];
               yy   = ph ? $signed(w[31:24]) : $signed(w[23:16]);
               cbv  = $signed(w[7:0]);
               crv  = $signed(w[15:8]);
               yp   = yy + 128;
               rr   = yp + ((90 * crv + 32) >>> 6);
               gg   = yp - ((22 * cbv + 46 * crv + 32) >>> 6);
               bbv  = yp + ((113 * cbv + 32) >>> 6);
               hit  = 0;
               mask = lodd ? 255 : 0;
               er   = sat8(rr, hit) ^ mask;
               eg   = sat8(gg, hit) ^ mask;
               eb   = sat8(bbv, hit) ^ mask;
               etag = {hit ? "R6" : "R5", lodd ? " R7" : "", " R3"};
               ev   = 1;
               if (ph == 1) void'(q.pop_front());
               ph ^= 1;
            end else begin
               eu = 1;
            end
         end
         if (ack[0]) begin pl = data; gl = 1; end
         if (ack[1]) begin pc = data; gc = 1; end
         if (gl && gc) begin q.push_back({pl, pc}); gl = 0; gc = 0; end
      end
   end

   // compare, then drive DMA acknowledges
   always begin
      logic [1:0] xreq;
      @(negedge clk);
      #2;
      xreq = (!rst_n || q.size() >= 2) ? 2'b00 : {~gc, ~gl};
      chk(etag, r, er, "red");
      chk(etag, g, eg, "green");
      chk(etag, b, eb, "blue");
      chk(rst_n ? vtag : "R1", ov, ev, "out_valid");
      chk(rst_n ? vtag : "R1", und, eu, "underflow");
      chk(rst_n ? "R2" : "R1", req, xreq, "dma_req");
      ack = 2'b00;
      if (rst_n && ack_en && int'($urandom % 100) >= stall) begin
         if (req[0]) begin
            ack = 2'b01;
            data = (nl < 3) ? dir_l[nl] : 16'($urandom);
            nl++;
         end else if (req[1]) begin
            ack = 2'b10;
            data = (nc < 3) ? dir_c[nc] : 16'($urandom);
            nc++;
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   initial begin
      step(4);                 // reset state checked (R1)
      rst_n = 1'b1;
      step(2);
      pv = 1'b1;               // no data yet: underflow (R8)
      step(3);
      pv = 1'b0;
      ack_en = 1'b1;           // fill both slots, requests drop (R2)
      step(12);
      for (int i = 0; i < 600; i++) begin   // back-to-back pixels (R4, R5, R7)
         pv = 1'b1;
         lodd = ((i / 16) % 2) == 1;
         step(1);
      end
      stall = 60;              // DMA slower than pixels (R8, R2)
      for (int i = 0; i < 1500; i++) begin
         pv = 1'b1;
         lodd = ((i / 24) % 2) == 1;
         step(1);
      end
      stall = 20;              // gaps in demand (R9)
      for (int i = 0; i < 2000; i++) begin
         pv = ($urandom % 3) != 0;
         lodd = ($urandom % 2) == 1;
         step(1);
      end
      pv = 1'b0;
      step(8);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule